// File: doc/BRIEF.md
# Stack Return Sequencer

This block carries out the five 16-bit real-mode return operations. A decoded opcode byte arrives with a start strobe, together with an optional 16-bit immediate and the current code segment, instruction pointer, stack pointer, stack segment and flags word. The block then reads one, two or three words from the stack through a word-wide read port that uses a request/valid handshake. After the last word it publishes the new instruction pointer, code segment, stack pointer and flags, and raises done for a single cycle.

The surrounding core keeps its own register file. It loads these values into the block, waits for done, and copies back the four result words. An opcode that is not a return finishes at once with an error indication. In that case no stack read is made and the result words keep their previous values.

Top module: `ret_sequencer`

## Requirements
- R1: Opcode 0xC3 reads one word into the instruction pointer, keeps the code segment and flags from the inputs, and leaves the stack pointer 2 above its start value.
- R2: Opcode 0xC2 behaves like 0xC3, then adds the 16-bit immediate to the stack pointer after the read.
- R3: Opcode 0xCB reads the instruction pointer from the start stack address, then the code segment from the word 2 bytes above it, and leaves the stack pointer 4 above its start value.
- R4: Opcode 0xCA behaves like 0xCB, then adds the immediate to the stack pointer after both reads.
- R5: Opcode 0xCF reads the instruction pointer, the code segment and the flags, in that order, from three ascending words, and leaves the stack pointer 6 above its start value.
- R6: Every read address is (stack segment × 16 + stack pointer) truncated to 20 bits. The stack pointer wraps modulo 65536. The address and the request stay stable until valid is seen.
- R7: The flags restored by 0xCF have bit 1 and bits 15:12 forced to 1 and bits 3 and 5 forced to 0. All other bits are taken from the word read.
- R8: The result outputs change only in the cycle where done is high. Done lasts exactly one cycle and follows the last accepted read.
- R9: Any other opcode raises err together with done in the cycle after start. It makes no memory request and leaves every result output unchanged.
- R10: A start received while busy is ignored. The operation in progress completes with its own inputs, and no extra done follows.
- R11: After reset, busy, done, err and the request are low and all result outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation when idle |
| opcode | input | 8 | Decoded opcode byte |
| imm | input | 16 | Stack release amount (used by 0xC2 and 0xCA) |
| cs_in | input | 16 | Current code segment |
| ip_in | input | 16 | Current instruction pointer |
| sp_in | input | 16 | Current stack pointer |
| ss_in | input | 16 | Current stack segment |
| flags_in | input | 16 | Current flags |
| mem_req | output | 1 | Stack read request |
| mem_addr | output | 20 | Physical read address |
| mem_valid | input | 1 | Read data valid |
| mem_rdata | input | 16 | Read data |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Unsupported opcode, high with done |
| ip_out | output | 16 | Resulting instruction pointer |
| cs_out | output | 16 | Resulting code segment |
| sp_out | output | 16 | Resulting stack pointer |
| flags_out | output | 16 | Resulting flags |

## Verification
The embedded assertions assume two things about the memory side. First, mem_valid is only raised while mem_req is high. Second, valid is high for exactly the one cycle in which the word is accepted, so each pulse stands for one word. The bench memory model follows both rules. It counts a chosen latency (zero to three cycles) only while a request is pending, returns the word for the presented address, and drops valid at the accepting edge. Opcode and register inputs are changed only at falling edges. A start that collides with a running operation is given deliberately, to show that it is discarded.

// File: rtl/ret_pkg.sv
package ret_pkg;
    localparam int WORD_W    = 16;
    localparam int SEG_SHIFT = 4;
    localparam int PHYS_W    = WORD_W + SEG_SHIFT;
    localparam int STEP      = WORD_W / 8;

    localparam logic [7:0] OPC_NEAR     = 8'hC3;
    localparam logic [7:0] OPC_NEAR_IMM = 8'hC2;
    localparam logic [7:0] OPC_FAR      = 8'hCB;
    localparam logic [7:0] OPC_FAR_IMM  = 8'hCA;
    localparam logic [7:0] OPC_IRET     = 8'hCF;

    localparam logic [WORD_W-1:0] FL_SET = 16'hF002;
    localparam logic [WORD_W-1:0] FL_CLR = 16'h0028;

    typedef enum logic [1:0] {K_NEAR, K_FAR, K_IRET, K_BAD} kind_e;
    typedef enum logic {S_IDLE, S_POP} state_e;

    typedef struct packed {
        state_e            st;
        kind_e             kind;
        logic [1:0]        idx;
        logic [1:0]        last;
        logic [WORD_W-1:0] sp_w;
        logic [WORD_W-1:0] ss_w;
        logic [WORD_W-1:0] ip_w;
        logic [WORD_W-1:0] cs_w;
        logic [WORD_W-1:0] fl_w;
        logic [WORD_W-1:0] imm_w;
        logic [WORD_W-1:0] ip_o;
        logic [WORD_W-1:0] cs_o;
        logic [WORD_W-1:0] sp_o;
        logic [WORD_W-1:0] fl_o;
        logic              done;
        logic              err;
    } seq_t;
endpackage

// File: rtl/ret_decode.sv
module ret_decode
    import ret_pkg::*;
(
    input  logic [7:0] opcode,
    output kind_e      kind,
    output logic [1:0] last_idx,
    output logic       use_imm,
    output logic       bad
);
    always_comb begin
        kind     = K_BAD;
        last_idx = 2'd0;
        use_imm  = 1'b0;
        unique case (opcode)
            OPC_NEAR:     begin kind = K_NEAR; last_idx = 2'd0; end
            OPC_NEAR_IMM: begin kind = K_NEAR; last_idx = 2'd0; use_imm = 1'b1; end
            OPC_FAR:      begin kind = K_FAR;  last_idx = 2'd1; end
            OPC_FAR_IMM:  begin kind = K_FAR;  last_idx = 2'd1; use_imm = 1'b1; end
            OPC_IRET:     begin kind = K_IRET; last_idx = 2'd2; end
            default:      kind = K_BAD;
        endcase
        bad = (kind == K_BAD);
    end
endmodule

// File: rtl/ret_addr.sv
module ret_addr
    import ret_pkg::*;
(
    input  logic [WORD_W-1:0] seg,
    input  logic [WORD_W-1:0] off,
    output logic [PHYS_W-1:0] phys
);
    localparam int PAD = PHYS_W - WORD_W;
    logic [PHYS_W-1:0] base;
    logic [PHYS_W-1:0] offx;

    always_comb begin
        base = {seg, {SEG_SHIFT{1'b0}}};
        offx = {{PAD{1'b0}}, off};
        phys = base + offx;
    end
endmodule

// File: rtl/ret_flagfix.sv
module ret_flagfix
    import ret_pkg::*;
(
    input  logic [WORD_W-1:0] raw,
    output logic [WORD_W-1:0] fixed
);
    always_comb begin
        fixed = (raw & ~FL_CLR) | FL_SET;
    end
endmodule

// File: rtl/ret_sequencer.sv
module ret_sequencer
    import ret_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [7:0]        opcode,
    input  logic [WORD_W-1:0] imm,
    input  logic [WORD_W-1:0] cs_in,
    input  logic [WORD_W-1:0] ip_in,
    input  logic [WORD_W-1:0] sp_in,
    input  logic [WORD_W-1:0] ss_in,
    input  logic [WORD_W-1:0] flags_in,
    output logic              mem_req,
    output logic [PHYS_W-1:0] mem_addr,
    input  logic              mem_valid,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic [WORD_W-1:0] ip_out,
    output logic [WORD_W-1:0] cs_out,
    output logic [WORD_W-1:0] sp_out,
    output logic [WORD_W-1:0] flags_out
);
    localparam logic [WORD_W-1:0] STEP_W = WORD_W'(STEP);

    seq_t  q, d;
    kind_e dec_kind;
    logic [1:0] dec_last;
    logic dec_imm, dec_bad;
    logic [WORD_W-1:0] fl_fixed;

    ret_decode u_dec (
        .opcode  (opcode),
        .kind    (dec_kind),
        .last_idx(dec_last),
        .use_imm (dec_imm),
        .bad     (dec_bad)
    );

    ret_addr u_addr (
        .seg (q.ss_w),
        .off (q.sp_w),
        .phys(mem_addr)
    );

    ret_flagfix u_fix (
        .raw  (mem_rdata),
        .fixed(fl_fixed)
    );

    always_comb begin
        logic [WORD_W-1:0] ip_n, cs_n, fl_n, sp_n;
        d      = q;
        d.done = 1'b0;
        d.err  = 1'b0;
        ip_n   = q.ip_w;
        cs_n   = q.cs_w;
        fl_n   = q.fl_w;
        sp_n   = q.sp_w + STEP_W;
        unique case (q.st)
            S_IDLE: begin
                if (start) begin
                    if (dec_bad) begin
                        d.done = 1'b1;
                        d.err  = 1'b1;
                    end else begin
                        d.st    = S_POP;
                        d.kind  = dec_kind;
                        d.idx   = 2'd0;
                        d.last  = dec_last;
                        d.sp_w  = sp_in;
                        d.ss_w  = ss_in;
                        d.ip_w  = ip_in;
                        d.cs_w  = cs_in;
                        d.fl_w  = flags_in;
                        d.imm_w = dec_imm ? imm : '0;
                    end
                end
            end
            S_POP: begin
                if (mem_valid) begin
                    unique case (q.idx)
                        2'd0:    ip_n = mem_rdata;
                        2'd1:    cs_n = mem_rdata;
                        default: fl_n = fl_fixed;
                    endcase
                    d.ip_w = ip_n;
                    d.cs_w = cs_n;
                    d.fl_w = fl_n;
                    d.sp_w = sp_n;
                    if (q.idx == q.last) begin
                        d.st   = S_IDLE;
                        d.ip_o = ip_n;
                        d.cs_o = cs_n;
                        d.fl_o = fl_n;
                        d.sp_o = sp_n + q.imm_w;
                        d.done = 1'b1;
                    end else begin
                        d.idx = q.idx + 2'd1;
                    end
                end
            end
            default: d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q      <= '0;
            q.st   <= S_IDLE;
            q.kind <= K_NEAR;
        end else begin
            q <= d;
        end
    end

    assign mem_req   = (q.st == S_POP);
    assign busy      = (q.st == S_POP);
    assign done      = q.done;
    assign err       = q.err;
    assign ip_out    = q.ip_o;
    assign cs_out    = q.cs_o;
    assign sp_out    = q.sp_o;
    assign flags_out = q.fl_o;

    // Waiting request holds its address
    assert_addr_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_valid) |=> (mem_req && $stable(mem_addr)));

    // Completion pulse lasts one cycle
    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // Results move only with done
    assert_out_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(ip_out) && $stable(cs_out) && $stable(sp_out) && $stable(flags_out)));

    // Error comes with done and no request
    assert_err_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (done && !mem_req));

    // Restored flags carry the forced bits
    assert_flags_fixed_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !err && q.kind == K_IRET) |->
            (flags_out[1] && !flags_out[3] && !flags_out[5] && (flags_out[15:12] == 4'hF)));

    // Start while busy produces no immediate done
    assert_busy_ignore_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && !mem_valid) |=> !done);
endmodule

// File: tb/sim_ret_sequencer.sv
module sim_ret_sequencer;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [7:0] opcode = 8'h00;
    logic [15:0] imm = '0, cs_in = '0, ip_in = '0, sp_in = '0, ss_in = '0, flags_in = '0;
    logic mem_req, mem_valid = 1'b0;
    logic [19:0] mem_addr;
    logic [15:0] mem_rdata = '0;
    logic busy, done, err;
    logic [15:0] ip_out, cs_out, sp_out, flags_out;

    int checks = 0;
    int errors = 0;
    int lat = 0;
    int waitc = 0;
    int cycles = 0;
    logic saw_req = 1'b0;

    always #2.5 clk = ~clk;

    ret_sequencer u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode), .imm(imm),
        .cs_in(cs_in), .ip_in(ip_in), .sp_in(sp_in), .ss_in(ss_in), .flags_in(flags_in),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_valid(mem_valid), .mem_rdata(mem_rdata),
        .busy(busy), .done(done), .err(err),
        .ip_out(ip_out), .cs_out(cs_out), .sp_out(sp_out), .flags_out(flags_out)
    );

    function automatic logic [15:0] memf(input logic [19:0] a);
        return a[15:0] ^ 16'h5A3C ^ {a[19:16], a[7:0], a[19:16]};
    endfunction

    function automatic logic [19:0] phys(input logic [15:0] s, input logic [15:0] o);
        return {s, 4'h0} + {4'h0, o};
    endfunction

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (mem_req) saw_req <= 1'b1;
        if (mem_valid) begin
            mem_valid <= 1'b0;
            waitc     <= 0;
        end else if (mem_req) begin
            if (waitc >= lat) begin
                mem_valid <= 1'b1;
                mem_rdata <= memf(mem_addr);
            end else begin
                waitc <= waitc + 1;
            end
        end
    end

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wait_done(input string tag, output bit ok);
        ok = 1'b0;
        for (int i = 0; i < 60; i++) begin
            if (done) begin ok = 1'b1; break; end
            @(negedge clk);
        end
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual no-done expected done", tag);
        end
    endtask

    logic [15:0] e_ip = '0, e_cs = '0, e_sp = '0, e_fl = '0;

    task automatic run_op(input logic [7:0] op, input logic [15:0] im, input logic [15:0] c,
                          input logic [15:0] ip, input logic [15:0] sp, input logic [15:0] ss,
                          input logic [15:0] fl, input int lt, input bit collide);
        bit ok;
        bit legal;
        string tag;
        legal = (op == 8'hC3) || (op == 8'hC2) || (op == 8'hCB) || (op == 8'hCA) || (op == 8'hCF);
        case (op)
            8'hC3: tag = "R1";
            8'hC2: tag = "R2";
            8'hCB: tag = "R3";
            8'hCA: tag = "R4";
            8'hCF: tag = "R5";
            default: tag = "R9";
        endcase
        @(negedge clk);
        lat = lt; saw_req = 1'b0;
        opcode = op; imm = im; cs_in = c; ip_in = ip; sp_in = sp; ss_in = ss; flags_in = fl;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (collide && busy) begin
            opcode = 8'hC3; sp_in = 16'h0000; ss_in = 16'h0000; ip_in = 16'h1111;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        wait_done(tag, ok);
        if (!ok) return;
        if (legal) begin
            e_ip = memf(phys(ss, sp));
            e_cs = c;
            e_fl = fl;
            e_sp = sp + 16'd2;
            if (op == 8'hCB || op == 8'hCA || op == 8'hCF) begin
                e_cs = memf(phys(ss, sp + 16'd2));
                e_sp = sp + 16'd4;
            end
            if (op == 8'hCF) begin
                e_fl = (memf(phys(ss, sp + 16'd4)) & 16'hFFD7) | 16'hF002;
                e_sp = sp + 16'd6;
            end
            if (op == 8'hC2 || op == 8'hCA) e_sp = e_sp + im;
        end
        check({tag, " err"}, {15'd0, err}, {15'd0, !legal});
        check({tag, " ip (R6 addr)"}, ip_out, e_ip);
        check({tag, " cs"}, cs_out, e_cs);
        check({tag, " sp"}, sp_out, e_sp);
        check({tag, " flags R7"}, flags_out, e_fl);
        if (!legal) check("R9 no request", {15'd0, saw_req}, 16'd0);
        @(negedge clk);
        check({tag, " R8 done one cycle"}, {15'd0, done}, 16'd0);
        if (collide) begin
            for (int i = 0; i < 8; i++) @(negedge clk);
            check("R10 no second done", {15'd0, done || busy}, 16'd0);
            check("R10 result kept", ip_out, e_ip);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R11 busy", {15'd0, busy}, 16'd0);
        check("R11 done/err/req", {13'd0, done, err, mem_req}, 16'd0);
        check("R11 ip", ip_out, 16'd0);
        check("R11 cs", cs_out, 16'd0);
        check("R11 sp", sp_out, 16'd0);
        check("R11 flags", flags_out, 16'd0);
        rst_n = 1'b1;
        for (int op = 0; op < 256; op++)
            run_op(8'(op), 16'h0010, 16'h2000, 16'h0030, 16'h00FA, 16'h0000, 16'h0ACE, op % 3, 1'b0);
        for (int k = 0; k < 5; k++) begin
            logic [7:0] opk;
            opk = (k == 0) ? 8'hC3 : (k == 1) ? 8'hC2 : (k == 2) ? 8'hCB : (k == 3) ? 8'hCA : 8'hCF;
            for (int s = 0; s < 4; s++)
                for (int g = 0; g < 3; g++)
                    for (int l = 0; l < 4; l++) begin
                        logic [15:0] spv, ssv;
                        spv = (s == 0) ? 16'h00FC : (s == 1) ? 16'hFFFE : (s == 2) ? 16'hFFFA : 16'h1230;
                        ssv = (g == 0) ? 16'h0000 : (g == 1) ? 16'hFFFF : 16'h2000;
                        run_op(opk, 16'hFFF0 + 16'(s * 8 + l), 16'h8000 + 16'(g), 16'h0100,
                               spv, ssv, 16'(l * 16'h1111), l, 1'b0);
                    end
        end
        run_op(8'hCF, 16'h0000, 16'h2000, 16'h0030, 16'h00FA, 16'h0100, 16'h0000, 3, 1'b1);
        run_op(8'hCA, 16'h0010, 16'h2000, 16'h0030, 16'h00FC, 16'h0100, 16'h0000, 2, 1'b1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        wait (cycles > 150000);
        errors++;
        $display("FAIL watchdog actual hung expected finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule